// File: doc/BRIEF.md
# Watchdog Timer with Two-Word Ordered Service

This block is a watchdog timer that sits on a simple memory-mapped register port. Firmware sets a 5-bit delay code and an enable bit. The count then runs for 2^(code+1) watchdog clock cycles. To restart the count, firmware writes one fixed 32-bit magic word to a first service register and then a second fixed magic word to a second service register.

A reset request goes out in three cases: the count expires, the service sequence is wrong, or software asks for a reset. When a request fires, the block also clears its own control state (configuration, counter and service sequencer) in the same way the system reset would. A 3-bit cause code is kept across that self-clear, so firmware can read it after reboot. Only the power-on reset input clears the cause code and the request logic.

Turning the watchdog off takes two steps. Firmware clears the enable bit, and then a valid two-word service commits the stop. An external user-reset input is also recorded with its own cause code.

Top module: `wdg_magic_kick`

## Requirements
- R1: After power-on reset, `rst_req_o` is 0, the configuration register at offset 0x04 reads 0, and the cause field reads 0.
- R2: Writing offset 0x04 with bit 31 set and delay D in bits [4:0] while stopped starts the count. Without service, `rst_req_o` rises exactly 2^(D+1) cycles after that write's clock edge, and the cause reads 1 (timeout).
- R3: A write of 0xABCD1234 to offset 0x08 followed by a write of 0x4321DCBA to offset 0x0C is a valid service. It restarts the count, so the next timeout comes 2^(D+1) cycles after the second write, and it raises no request.
- R4: Writing any value other than 0xABCD1234 to offset 0x08, or any value other than 0x4321DCBA to offset 0x0C after an arming write, raises a request with cause 2 (incorrect service).
- R5: A write to offset 0x0C with no valid arming write to 0x08 before it raises a request with cause 2, even when the value is 0x4321DCBA.
- R6: Writing offset 0x00 with bit 0 = 1 raises a request on the next edge with cause 3 (software). A write there with bit 0 = 0 has no effect.
- R7: Clearing bit 31 of 0x04 while counting does not stop the count. A valid service that follows it stops the count.
- R8: Each request from the block holds `rst_req_o` high for exactly 4 cycles. Triggers that arrive while a request is active are ignored.
- R9: A request clears the configuration register to 0 and stops the count. The cause code, read from bits [2:0] of offset 0x08 (other bits read 0), is kept. Read data appears on `bus_rdata` one cycle after `bus_rd`.
- R10: A delay written while counting takes effect only at the next restart. The current count still ends with the old delay.
- R11: While stopped, the counter stays at zero and no timeout request is produced.
- R12: A valid service whose second write lands in the last cycle of the count restarts it, and no request is raised.
- R13: When idle, a high `usr_rst_i` sets the cause to 4, clears the configuration and counter, and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| usr_rst_i | input | 1 | External user reset indication |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The count can expire in the same cycle that the second service word is written. The bench arms the first word so that the second one is sampled on the very edge that would raise the timeout. It then checks that no request appears and that the next timeout comes a full period after that edge. The bench also sets a delay-field change against a running count and a pending stop against expiry. In both cases it counts exact cycles to the request edge and reads back the stored cause code afterwards.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [2:0] {
        CAUSE_POR     = 3'd0,
        CAUSE_TIMEOUT = 3'd1,
        CAUSE_BADSVC  = 3'd2,
        CAUSE_SOFT    = 3'd3,
        CAUSE_USER    = 3'd4
    } cause_e;

    localparam logic [31:0] SVC_WORD_A = 32'hABCD1234;
    localparam logic [31:0] SVC_WORD_B = 32'h4321DCBA;

    localparam logic [3:0] OFS_SOFT = 4'h0;
    localparam logic [3:0] OFS_CFG  = 4'h4;
    localparam logic [3:0] OFS_SVCA = 4'h8;
    localparam logic [3:0] OFS_SVCB = 4'hC;

endpackage

// File: rtl/wdg_bus.sv
module wdg_bus #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int DELAY_W = 5
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               cfg_en,
    input  logic [DELAY_W-1:0] cfg_delay,
    input  wdg_pkg::cause_e    cause,
    output logic               cfg_wr,
    output logic               cfg_en_wr,
    output logic [DELAY_W-1:0] cfg_delay_wr,
    output logic               soft_req,
    output logic               svca_wr,
    output logic               svca_match,
    output logic               svcb_wr,
    output logic               svcb_match
);
    import wdg_pkg::*;

    localparam int EN_BIT = DATA_W - 1;
    localparam int PAD_W  = DATA_W - DELAY_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      soft_wr;

    always_comb begin
        cfg_wr       = bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
        soft_wr      = bus_wr && (bus_addr == ADDR_W'(OFS_SOFT));
        svca_wr      = bus_wr && (bus_addr == ADDR_W'(OFS_SVCA));
        svcb_wr      = bus_wr && (bus_addr == ADDR_W'(OFS_SVCB));
        soft_req     = soft_wr && bus_wdata[0];
        svca_match   = (bus_wdata == DATA_W'(SVC_WORD_A));
        svcb_match   = (bus_wdata == DATA_W'(SVC_WORD_B));
        cfg_en_wr    = bus_wdata[EN_BIT];
        cfg_delay_wr = bus_wdata[DELAY_W-1:0];

        st_d = st_q;
        if (bus_rd) begin
            if (bus_addr == ADDR_W'(OFS_CFG))
                st_d.rdata = {cfg_en, {PAD_W{1'b0}}, cfg_delay};
            else if (bus_addr == ADDR_W'(OFS_SVCA))
                st_d.rdata = {{(DATA_W-3){1'b0}}, cause};
            else
                st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/wdg_seq.sv
module wdg_seq (
    input  logic clk,
    input  logic por_n,
    input  logic clear,
    input  logic svca_wr,
    input  logic svca_match,
    input  logic svcb_wr,
    input  logic svcb_match,
    output logic svc_valid,
    output logic svc_bad
);
    typedef struct packed {
        logic armed;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        svc_valid = svcb_wr && st_q.armed && svcb_match;
        svc_bad   = (svca_wr && !svca_match) ||
                    (svcb_wr && !(st_q.armed && svcb_match));

        st_d = st_q;
        if (clear)        st_d.armed = 1'b0;
        else if (svca_wr) st_d.armed = svca_match;
        else if (svcb_wr) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
    parameter int DELAY_W = 5,
    parameter int CNT_W   = (1 << DELAY_W) + 1
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               clear,
    input  logic               cfg_wr,
    input  logic               cfg_en_wr,
    input  logic [DELAY_W-1:0] cfg_delay_wr,
    input  logic               svc_valid,
    output logic               cfg_en,
    output logic [DELAY_W-1:0] cfg_delay,
    output logic               run,
    output logic [CNT_W-1:0]   cnt,
    output logic               expire
);
    typedef struct packed {
        logic               en;
        logic [DELAY_W-1:0] delay;
        logic               run;
        logic [DELAY_W-1:0] act_delay;
        logic [CNT_W-1:0]   cnt;
    } cnt_state_t;

    cnt_state_t       st_d, st_q;
    logic [DELAY_W:0] shamt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        shamt  = {1'b0, st_q.act_delay} + 1'b1;
        limit  = (CNT_W'(1) << shamt) - CNT_W'(1);
        expire = st_q.run && (st_q.cnt == limit);

        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (cfg_wr) begin
            st_d.en    = cfg_en_wr;
            st_d.delay = cfg_delay_wr;
            if (cfg_en_wr && !st_q.run) begin
                st_d.run       = 1'b1;
                st_d.cnt       = '0;
                st_d.act_delay = cfg_delay_wr;
            end else if (st_q.run) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else if (svc_valid && st_q.run) begin
            st_d.cnt       = '0;
            st_d.act_delay = st_q.delay;
            st_d.run       = st_q.en;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_en    = st_q.en;
    assign cfg_delay = st_q.delay;
    assign run       = st_q.run;
    assign cnt       = st_q.cnt;

endmodule

// File: rtl/wdg_cause.sv
module wdg_cause #(
    parameter int PULSE_LEN = 4,
    parameter int PLS_W     = $clog2(PULSE_LEN + 1)
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            expire,
    input  logic            svc_valid,
    input  logic            svc_bad,
    input  logic            soft_req,
    input  logic            usr_rst_i,
    output logic            rst_req_o,
    output wdg_pkg::cause_e cause,
    output logic            clear
);
    import wdg_pkg::*;

    typedef struct packed {
        logic [PLS_W-1:0] pcnt;
        cause_e           cause;
    } cause_state_t;

    cause_state_t st_d, st_q;
    logic idle, t_timeout, fire, usr_take;

    always_comb begin
        idle      = (st_q.pcnt == '0);
        t_timeout = expire && !svc_valid;
        fire      = idle && (t_timeout || svc_bad || soft_req);
        usr_take  = idle && !fire && usr_rst_i;
        clear     = fire || usr_take || !idle;

        st_d = st_q;
        if (fire) begin
            st_d.pcnt = PLS_W'(PULSE_LEN);
            if (t_timeout)    st_d.cause = CAUSE_TIMEOUT;
            else if (svc_bad) st_d.cause = CAUSE_BADSVC;
            else              st_d.cause = CAUSE_SOFT;
        end else begin
            if (!idle)    st_d.pcnt  = st_q.pcnt - PLS_W'(1);
            if (usr_take) st_d.cause = CAUSE_USER;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{pcnt: '0, cause: CAUSE_POR};
        else        st_q <= st_d;
    end

    assign rst_req_o = !idle;
    assign cause     = st_q.cause;

endmodule

// File: rtl/wdg_magic_kick.sv
module wdg_magic_kick #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int DELAY_W   = 5,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              usr_rst_i,
    output logic              rst_req_o
);
    import wdg_pkg::*;

    localparam int CNT_W = (1 << DELAY_W) + 1;

    logic               cfg_wr, cfg_en_wr, soft_req;
    logic [DELAY_W-1:0] cfg_delay_wr, cfg_delay;
    logic               svca_wr, svca_match, svcb_wr, svcb_match;
    logic               svc_valid, svc_bad, clear;
    logic               cfg_en, run_w, expire_w;
    logic [CNT_W-1:0]   cnt_w;
    cause_e             cause_w;

    wdg_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DELAY_W(DELAY_W)) u_bus (
        .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_en(cfg_en), .cfg_delay(cfg_delay), .cause(cause_w),
        .cfg_wr(cfg_wr), .cfg_en_wr(cfg_en_wr), .cfg_delay_wr(cfg_delay_wr),
        .soft_req(soft_req), .svca_wr(svca_wr), .svca_match(svca_match),
        .svcb_wr(svcb_wr), .svcb_match(svcb_match)
    );

    wdg_seq u_seq (
        .clk(clk), .por_n(por_n), .clear(clear),
        .svca_wr(svca_wr), .svca_match(svca_match),
        .svcb_wr(svcb_wr), .svcb_match(svcb_match),
        .svc_valid(svc_valid), .svc_bad(svc_bad)
    );

    wdg_count #(.DELAY_W(DELAY_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .por_n(por_n), .clear(clear),
        .cfg_wr(cfg_wr), .cfg_en_wr(cfg_en_wr), .cfg_delay_wr(cfg_delay_wr),
        .svc_valid(svc_valid), .cfg_en(cfg_en), .cfg_delay(cfg_delay),
        .run(run_w), .cnt(cnt_w), .expire(expire_w)
    );

    wdg_cause #(.PULSE_LEN(PULSE_LEN)) u_cause (
        .clk(clk), .por_n(por_n), .expire(expire_w), .svc_valid(svc_valid),
        .svc_bad(svc_bad), .soft_req(soft_req), .usr_rst_i(usr_rst_i),
        .rst_req_o(rst_req_o), .cause(cause_w), .clear(clear)
    );

endmodule

// File: rtl/wdg_magic_kick_chk.sv
module wdg_magic_kick_chk #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 33,
    parameter int PULSE_LEN = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              usr_rst_i,
    input logic              rst_req_o,
    input logic              run_w,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [2:0]        cause_w,
    input logic              expire_w
);
    localparam int HC_W = $clog2(PULSE_LEN + 1) + 1;

    logic [HC_W-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         hi_cnt_q <= '0;
        else if (rst_req_o) hi_cnt_q <= hi_cnt_q + HC_W'(1);
        else                hi_cnt_q <= '0;
    end

    // R8: request never longer than the pulse length
    p_pulse_max_r8: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |-> (hi_cnt_q < HC_W'(PULSE_LEN)));

    // R8: request falls only after a full pulse
    p_pulse_len_r8: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_req_o) |-> (hi_cnt_q == HC_W'(PULSE_LEN)));

    // R6: software reset write raises request with cause 3
    p_soft_r6: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr == ADDR_W'(0) && bus_wdata[0] && !rst_req_o && !expire_w)
        |=> (rst_req_o && cause_w == 3'd3));

    // R4: wrong first service word raises request with cause 2
    p_bad_word_r4: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr && bus_addr == ADDR_W'(8) && bus_wdata != DATA_W'(32'hABCD1234)
         && !rst_req_o && !expire_w)
        |=> (rst_req_o && cause_w == 3'd2));

    // R11: stopped counter stays at zero
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!por_n)
        !run_w |-> (cnt_w == '0));

    // R13: user reset records cause 4 without a request
    p_user_r13: assert property (@(posedge clk) disable iff (!por_n)
        (usr_rst_i && !rst_req_o && !bus_wr && !expire_w)
        |=> (!rst_req_o && cause_w == 3'd4 && !run_w));

    // R9: cause code stays within the defined set
    p_cause_legal_r9: assert property (@(posedge clk) disable iff (!por_n)
        cause_w <= 3'd4);

endmodule

bind wdg_magic_kick wdg_magic_kick_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
    .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .usr_rst_i(usr_rst_i), .rst_req_o(rst_req_o),
    .run_w(run_w), .cnt_w(cnt_w), .cause_w(cause_w), .expire_w(expire_w)
);

// File: tb/test_wdg_magic_kick.sv
module test_wdg_magic_kick;

    localparam logic [31:0] WA = 32'hABCD1234;
    localparam logic [31:0] WB = 32'h4321DCBA;
    localparam logic [31:0] EN = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        usr_rst_i = 1'b0;
    logic        rst_req_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wdg_magic_kick i_wdg_magic_kick (
        .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .usr_rst_i(usr_rst_i), .rst_req_o(rst_req_o)
    );

    // vector: {addr[3:0], wdata[31:0], exp_req, exp_cause[2:0]}
    localparam logic [39:0] VEC [0:11] = '{
        {4'h0, 32'h0000_0000, 1'b0, 3'd0},   // R6 bit0 clear ignored
        {4'h0, 32'h0000_0001, 1'b1, 3'd3},   // R6 soft reset
        {4'hC, WB,            1'b1, 3'd2},   // R5 second word unarmed
        {4'h0, 32'h0000_0001, 1'b1, 3'd3},   // R6
        {4'h8, 32'h1234_5678, 1'b1, 3'd2},   // R4 wrong first word
        {4'h0, 32'hFFFF_FFFE, 1'b0, 3'd2},   // R6 bit0 clear ignored
        {4'h0, 32'h0000_0001, 1'b1, 3'd3},   // R6
        {4'h8, WA,            1'b0, 3'd3},   // R3 arm
        {4'hC, 32'hDEAD_BEEF, 1'b1, 3'd2},   // R4 wrong second word
        {4'h8, WA,            1'b0, 3'd2},   // R3 arm
        {4'hC, WB,            1'b0, 3'd2},   // R3 valid service
        {4'h4, 32'h0000_001F, 1'b0, 3'd2}    // R1 config write w/o enable
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    // n edges remain until the request edge
    task automatic expect_req_in(input string req, input int n);
        idle(n - 1);
        check(req, {31'b0, rst_req_o}, 32'd0);
        idle(1);
        check(req, {31'b0, rst_req_o}, 32'd1);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int hi;
        idle(3);
        por_n = 1'b1;
        idle(2);

        // R1 reset state
        check("R1 req", {31'b0, rst_req_o}, 32'd0);
        rd(4'h4, r); check("R1 cfg", r, 32'd0);
        rd(4'h8, r); check("R1 cause", r, 32'd0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][39:36], VEC[i][35:4]);
            check($sformatf("vec%0d req R4/R5/R6", i), {31'b0, rst_req_o}, {31'b0, VEC[i][3]});
            rd(4'h8, r);
            check($sformatf("vec%0d cause R4/R5/R6", i), r, {29'b0, VEC[i][2:0]});
            idle(6);
        end

        // R2 timeout with D=2 -> 8 cycles; R8 pulse width; R9 cause survives
        wr(4'h4, EN | 32'd2);
        expect_req_in("R2 timeout edge", 8);
        hi = 1;
        for (int k = 0; k < 6; k++) begin
            idle(1);
            if (rst_req_o) hi++;
        end
        check("R8 pulse width", hi, 32'd4);
        rd(4'h8, r); check("R2 cause timeout", r, 32'd1);
        rd(4'h4, r); check("R9 cfg cleared", r, 32'd0);

        // R3 service restarts count
        wr(4'h4, EN | 32'd2);
        idle(3);
        wr(4'h8, WA);
        wr(4'hC, WB);
        expect_req_in("R3 restart", 8);
        idle(6);

        // R12 service completing in the expiry cycle
        wr(4'h4, EN | 32'd2);
        idle(6);
        wr(4'h8, WA);
        wr(4'hC, WB);
        check("R12 no request", {31'b0, rst_req_o}, 32'd0);
        expect_req_in("R12 restart", 8);
        idle(6);

        // R10 delay change waits for restart
        wr(4'h4, EN | 32'd2);
        wr(4'h4, EN | 32'd4);
        expect_req_in("R10 old delay", 7);
        idle(6);
        wr(4'h4, EN | 32'd2);
        wr(4'h4, EN | 32'd3);
        wr(4'h8, WA);
        wr(4'hC, WB);
        expect_req_in("R10 new delay", 16);
        idle(6);

        // R7 clearing enable alone does not stop
        wr(4'h4, EN | 32'd2);
        wr(4'h4, 32'd2);
        expect_req_in("R7 pending stop", 7);
        idle(6);

        // R7/R11 stop committed by service
        wr(4'h4, EN | 32'd2);
        wr(4'h4, 32'd2);
        wr(4'h8, WA);
        wr(4'hC, WB);
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            idle(1);
            if (rst_req_o) hi++;
        end
        check("R11 no timeout while stopped", hi, 32'd0);
        rd(4'h4, r); check("R7 cfg after stop", r, 32'd2);

        // R13 user reset
        wr(4'h4, EN | 32'd2);
        usr_rst_i = 1'b1;
        idle(1);
        usr_rst_i = 1'b0;
        check("R13 no request", {31'b0, rst_req_o}, 32'd0);
        rd(4'h8, r); check("R13 cause user", r, 32'd4);
        rd(4'h4, r); check("R13 cfg cleared", r, 32'd0);
        hi = 0;
        for (int k = 0; k < 20; k++) begin
            idle(1);
            if (rst_req_o) hi++;
        end
        check("R13 counter cleared", hi, 32'd0);

        // R8 trigger during active pulse ignored
        wr(4'h0, 32'd1);
        wr(4'h8, 32'h0);
        rd(4'h8, r); check("R8 cause kept during pulse", r, 32'd3);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule